// File: doc/BRIEF.md
# Peripheral Clock-Gating Standby Controller

This block decides which on-chip peripherals receive a clock. Software owns a standby register with one bit per peripheral. Setting a bit to 1 drops that peripheral's clock-enable, and setting it back to 0 raises it again. A bus fabric also presents a per-peripheral select vector. The block splits that vector into accesses that may pass and accesses that must be blocked, because their target is in standby.

Every register write first sits in a one-cycle pending stage and only then commits. A read aimed at a register that still has a write pending is held back for one cycle. The read data therefore always reflects the committed value, and software can confirm a cleared standby bit by reading it back.

There are two reset inputs, both synchronous and active low.
- The external reset pin clears everything.
- Power-on reset clears only the standby bits of four always-restorable peripherals.

A second control register carries two sticky bits. Each of them locks at 1 when a deep-standby entry strobe arrives while it is set. After that it can be cleared only through the external reset pin.

Top module: `pdn_standby_ctrl`

## Requirements
- R1: While `rst_pin_n` is low at a clock edge, the block clears all standby bits (so every `clk_en` bit is 1), control register 2, both locks and any pending write. After release, reads of both registers return 0.
- R2: Bit i of the standby register (offset 0x0) drives `clk_en[i]` inverted. A committed 1 drops the enable and a committed 0 restores it.
- R3: A write accepted at edge k is pending after edge k. It commits at edge k+1. `clk_en` keeps its old value until edge k+1.
- R4: A read sampled while a write to the same register is pending raises `bus_rvalid` only after the second following edge. That read returns the newly committed value. Any other read raises `bus_rvalid` after the next edge, with the committed value in `bus_rdata`.
- R5: A power-on reset (`por_n` low at an edge, `rst_pin_n` high) clears standby bits 0 to 3 and leaves bits 4 and up unchanged. It also leaves control register 2 and its locks unchanged.
- R6: `periph_blk` equals `periph_sel & standby` and `periph_pass` equals `periph_sel & ~standby`, combinationally.
- R7: Control register 2 sits at offset 0x4 and has 8 bits. If bit 7 or bit 6 is 1 on the edge where `dstby_entry` is high, that bit locks, and later writes of 0 to it leave it at 1.
- R8: Writes of 1 to bits 7 and 6 are always accepted. A bit that was 0 at the strobe stays clearable. Bits 5 to 0 are always plain read/write.
- R9: A lock persists through power-on reset. Only `rst_pin_n` low removes it, after which bits 7 and 6 can be written to 0 again.
- R10: Addresses other than 0x0 and 0x4 read as 0, and writes to them change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_pin_n | input | 1 | External reset pin, synchronous, active low, full reset |
| por_n | input | 1 | Power-on reset, synchronous, active low, partial reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | 4 | Register byte offset |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data, valid with `bus_rvalid` |
| bus_rvalid | output | 1 | One-cycle read response strobe |
| dstby_entry | input | 1 | Deep-standby entry strobe |
| periph_sel | input | 16 | Per-peripheral access request from the fabric |
| clk_en | output | 16 | Per-peripheral clock enable |
| periph_blk | output | 16 | Access blocked: target is in standby |
| periph_pass | output | 16 | Access allowed through to the peripheral |

## Verification
The state hardest to reach from the ports is a lock that must survive a power-on reset and then fall only to the reset pin. Reaching it takes several steps in order: a committed write that sets bit 7 and bit 6, then a deep-standby strobe, then a clearing write that must not take effect, then a power-on pulse, then a second clearing write, and only then a reset-pin pulse. The bench runs that whole chain, and a second chain in which only bit 6 is locked, to show that the unlocked bit 7 still clears. To reach the stall window, a read is issued in the very cycle after a write to the same register, when the pending stage is occupied.

// File: rtl/pdn_pkg.sv
// Package: shared register offsets, the write-target type and the address decoder
// for the standby controller. Assumes a 4-bit byte offset on the register bus.
package pdn_pkg;

    localparam int PDN_ADDR_W = 4;

    localparam logic [PDN_ADDR_W-1:0] OFS_STBY = 4'h0;
    localparam logic [PDN_ADDR_W-1:0] OFS_CR2  = 4'h4;

    typedef enum logic [1:0] {
        TGT_NONE = 2'd0,
        TGT_STBY = 2'd1,
        TGT_CR2  = 2'd2
    } pdn_tgt_e;

    // Map a byte offset to the register it selects; unmapped offsets give TGT_NONE.
    function automatic pdn_tgt_e pdn_decode(input logic [PDN_ADDR_W-1:0] a);
        pdn_tgt_e t;
        case (a)
            OFS_STBY: t = TGT_STBY;
            OFS_CR2:  t = TGT_CR2;
            default:  t = TGT_NONE;
        endcase
        return t;
    endfunction

endpackage

// File: rtl/pdn_wr_stage.sv
// Module: pdn_wr_stage
// Holds an accepted register write for exactly one cycle before it commits.
// Assumes the target has already been decoded; writes to unmapped offsets are
// dropped here. rst_n is the AND of both reset inputs.
module pdn_wr_stage
    import pdn_pkg::*;
#(
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr,
    input  pdn_tgt_e          wr_tgt,
    input  logic [DATA_W-1:0] wdata,
    output pdn_tgt_e          pend_tgt,
    output logic [DATA_W-1:0] pend_data
);

    // Capture the write target and data; an idle cycle leaves the stage empty.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend_tgt  <= TGT_NONE;
            pend_data <= '0;
        end else begin
            pend_tgt  <= wr ? wr_tgt : TGT_NONE;
            pend_data <= wdata;
        end
    end

endmodule

// File: rtl/pdn_stby_reg.sv
// Module: pdn_stby_reg
// Standby register, one bit per peripheral. The reset pin clears every bit.
// Power-on reset clears only the low NPOR bits. Otherwise the register takes
// committed writes. Assumes NPOR < NMOD.
module pdn_stby_reg #(
    parameter int NMOD = 16,
    parameter int NPOR = 4
) (
    input  logic            clk,
    input  logic            rst_pin_n,
    input  logic            por_n,
    input  logic            commit,
    input  logic [NMOD-1:0] commit_data,
    output logic [NMOD-1:0] stby_q
);

    localparam int KEEP_W = NMOD - NPOR;
    localparam logic [NMOD-1:0] POR_CLR = {{KEEP_W{1'b0}}, {NPOR{1'b1}}};

    // Apply pin reset, then partial power-on clear, then committed writes.
    always_ff @(posedge clk) begin
        if (!rst_pin_n) begin
            stby_q <= '0;
        end else if (!por_n) begin
            stby_q <= stby_q & ~POR_CLR;
        end else if (commit) begin
            stby_q <= commit_data;
        end
    end

endmodule

// File: rtl/pdn_cr2_lock.sv
// Module: pdn_cr2_lock
// Control register 2 with sticky top bits. A top bit that is 1 when the
// deep-standby strobe arrives locks, and a locked bit ignores writes of 0.
// Only the reset pin clears the register and the locks; power-on reset is not
// an input here on purpose.
module pdn_cr2_lock #(
    parameter int CR2_W  = 8,
    parameter int LOCK_W = 2
) (
    input  logic              clk,
    input  logic              rst_pin_n,
    input  logic              commit,
    input  logic [CR2_W-1:0]  commit_data,
    input  logic              dstby,
    output logic [CR2_W-1:0]  cr2_q,
    output logic [LOCK_W-1:0] lock_q
);

    localparam int LOW_W = CR2_W - LOCK_W;

    logic [CR2_W-1:0] lock_force;
    assign lock_force = {lock_q, {LOW_W{1'b0}}};

    // Store committed writes, keeping any locked bit at 1.
    always_ff @(posedge clk) begin
        if (!rst_pin_n) begin
            cr2_q <= '0;
        end else if (commit) begin
            cr2_q <= commit_data | lock_force;
        end
    end

    // Latch locks for top bits that are set at deep-standby entry.
    always_ff @(posedge clk) begin
        if (!rst_pin_n) begin
            lock_q <= '0;
        end else if (dstby) begin
            lock_q <= lock_q | cr2_q[CR2_W-1 -: LOCK_W];
        end
    end

endmodule

// File: rtl/pdn_standby_ctrl.sv
// Module: pdn_standby_ctrl (top)
// Peripheral clock-gating standby controller: register bus front end, pending
// write stage, standby register, locked control register 2 and per-peripheral
// enable and access gating.
// Assumes at most one outstanding read: no new read during a stalled one.
module pdn_standby_ctrl
    import pdn_pkg::*;
#(
    parameter int NMOD   = 16,
    parameter int NPOR   = 4,
    parameter int DATA_W = 16,
    parameter int CR2_W  = 8,
    parameter int LOCK_W = 2
) (
    input  logic                  clk,
    input  logic                  rst_pin_n,
    input  logic                  por_n,
    input  logic                  bus_wr,
    input  logic                  bus_rd,
    input  logic [PDN_ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0]     bus_wdata,
    output logic [DATA_W-1:0]     bus_rdata,
    output logic                  bus_rvalid,
    input  logic                  dstby_entry,
    input  logic [NMOD-1:0]       periph_sel,
    output logic [NMOD-1:0]       clk_en,
    output logic [NMOD-1:0]       periph_blk,
    output logic [NMOD-1:0]       periph_pass
);

    logic              rst_any_n;
    pdn_tgt_e          bus_tgt;
    pdn_tgt_e          pend_tgt;
    logic [DATA_W-1:0] pend_data;
    logic              stby_commit;
    logic              cr2_commit;
    logic [NMOD-1:0]   stby_q;
    logic [CR2_W-1:0]  cr2_q;
    logic [LOCK_W-1:0] lock_q;
    logic              rd_hit_pend;
    logic              rd_hold;
    pdn_tgt_e          rd_hold_tgt;
    pdn_tgt_e          rd_tgt;
    logic [DATA_W-1:0] rd_word;

    assign rst_any_n   = rst_pin_n & por_n;
    assign bus_tgt     = pdn_decode(bus_addr);
    assign stby_commit = (pend_tgt == TGT_STBY);
    assign cr2_commit  = (pend_tgt == TGT_CR2);
    assign rd_hit_pend = bus_rd && (pend_tgt != TGT_NONE) && (pend_tgt == bus_tgt);

    pdn_wr_stage #(.DATA_W(DATA_W)) u_wr_stage (
        .clk       (clk),
        .rst_n     (rst_any_n),
        .wr        (bus_wr),
        .wr_tgt    (bus_tgt),
        .wdata     (bus_wdata),
        .pend_tgt  (pend_tgt),
        .pend_data (pend_data)
    );

    pdn_stby_reg #(.NMOD(NMOD), .NPOR(NPOR)) u_stby (
        .clk         (clk),
        .rst_pin_n   (rst_pin_n),
        .por_n       (por_n),
        .commit      (stby_commit),
        .commit_data (pend_data[NMOD-1:0]),
        .stby_q      (stby_q)
    );

    pdn_cr2_lock #(.CR2_W(CR2_W), .LOCK_W(LOCK_W)) u_cr2 (
        .clk         (clk),
        .rst_pin_n   (rst_pin_n),
        .commit      (cr2_commit),
        .commit_data (pend_data[CR2_W-1:0]),
        .dstby       (dstby_entry),
        .cr2_q       (cr2_q),
        .lock_q      (lock_q)
    );

    // Select the committed register word for the read in progress.
    always_comb begin
        rd_tgt = rd_hold ? rd_hold_tgt : bus_tgt;
        case (rd_tgt)
            TGT_STBY: rd_word = DATA_W'(stby_q);
            TGT_CR2:  rd_word = DATA_W'(cr2_q);
            default:  rd_word = '0;
        endcase
    end

    // Answer reads next cycle, or one cycle later when a write to the same register is pending.
    always_ff @(posedge clk) begin
        if (!rst_any_n) begin
            rd_hold     <= 1'b0;
            rd_hold_tgt <= TGT_NONE;
            bus_rvalid  <= 1'b0;
            bus_rdata   <= '0;
        end else begin
            bus_rvalid <= 1'b0;
            if (rd_hold) begin
                rd_hold    <= 1'b0;
                bus_rdata  <= rd_word;
                bus_rvalid <= 1'b1;
            end else if (rd_hit_pend) begin
                rd_hold     <= 1'b1;
                rd_hold_tgt <= bus_tgt;
            end else if (bus_rd) begin
                bus_rdata  <= rd_word;
                bus_rvalid <= 1'b1;
            end
        end
    end

    // Per-peripheral clock enable and access steering.
    for (genvar g = 0; g < NMOD; g++) begin : g_mod
        assign clk_en[g]      = ~stby_q[g];
        assign periph_blk[g]  = periph_sel[g] & stby_q[g];
        assign periph_pass[g] = periph_sel[g] & ~stby_q[g];
    end

endmodule

// File: rtl/pdn_standby_chk.sv
// Module: pdn_standby_chk
// Assertion checker for pdn_standby_ctrl, attached by the bind below. Watches
// ports and the internal commit, pending-hit, standby and lock signals.
module pdn_standby_chk #(
    parameter int NMOD   = 16,
    parameter int NPOR   = 4,
    parameter int LOCK_W = 2
) (
    input logic              clk,
    input logic              rst_pin_n,
    input logic              por_n,
    input logic              bus_rd,
    input logic              bus_rvalid,
    input logic              rd_hit_pend,
    input logic              stby_commit,
    input logic [NMOD-1:0]   clk_en,
    input logic [NMOD-1:0]   periph_blk,
    input logic [NMOD-1:0]   periph_pass,
    input logic [NMOD-1:0]   stby_q,
    input logic [LOCK_W-1:0] cr2_hi,
    input logic [LOCK_W-1:0] lock_q
);

    logic armed;

    // Mark that at least one edge has passed since the reset pin released.
    always_ff @(posedge clk) begin
        if (!rst_pin_n) armed <= 1'b0;
        else            armed <= 1'b1;
    end

    p_clken_on_commit_r3: assert property (@(posedge clk) disable iff (!rst_pin_n)
        (armed && !$stable(clk_en)) |-> ($past(stby_commit) || !$past(por_n)));

    p_por_clears_low_r5: assert property (@(posedge clk) disable iff (!rst_pin_n)
        !por_n |=> (stby_q[NPOR-1:0] == '0));

    p_por_keeps_high_r5: assert property (@(posedge clk) disable iff (!rst_pin_n)
        !por_n |=> (stby_q[NMOD-1:NPOR] == $past(stby_q[NMOD-1:NPOR])));

    p_blocked_gated_r6: assert property (@(posedge clk) disable iff (!rst_pin_n)
        ((periph_blk & clk_en) == '0) && ((periph_blk & periph_pass) == '0));

    p_read_stall_r4: assert property (@(posedge clk) disable iff (!rst_pin_n)
        (bus_rd && rd_hit_pend) |=> !bus_rvalid);

    p_locked_bits_set_r7: assert property (@(posedge clk) disable iff (!rst_pin_n)
        armed |-> ((cr2_hi & lock_q) == lock_q));

    p_lock_sticky_r9: assert property (@(posedge clk) disable iff (!rst_pin_n)
        armed |-> ((lock_q & $past(lock_q)) == $past(lock_q)));

endmodule

bind pdn_standby_ctrl pdn_standby_chk #(
    .NMOD   (NMOD),
    .NPOR   (NPOR),
    .LOCK_W (LOCK_W)
) u_chk (
    .clk         (clk),
    .rst_pin_n   (rst_pin_n),
    .por_n       (por_n),
    .bus_rd      (bus_rd),
    .bus_rvalid  (bus_rvalid),
    .rd_hit_pend (rd_hit_pend),
    .stby_commit (stby_commit),
    .clk_en      (clk_en),
    .periph_blk  (periph_blk),
    .periph_pass (periph_pass),
    .stby_q      (stby_q),
    .cr2_hi      (cr2_q[CR2_W-1 -: LOCK_W]),
    .lock_q      (lock_q)
);

// File: tb/tb_pdn_standby_ctrl.sv
// Scoreboard bench for pdn_standby_ctrl: read tasks queue expected words, a
// monitor pops them on each read response; direct checks cover the enables.
module tb_pdn_standby_ctrl;

    logic        clk = 1'b0;
    logic        rst_pin_n;
    logic        por_n;
    logic        bus_wr;
    logic        bus_rd;
    logic [3:0]  bus_addr;
    logic [15:0] bus_wdata;
    logic [15:0] bus_rdata;
    logic        bus_rvalid;
    logic        dstby_entry;
    logic [15:0] periph_sel;
    logic [15:0] clk_en;
    logic [15:0] periph_blk;
    logic [15:0] periph_pass;

    int n_cmp = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    logic [15:0] exp_q[$];
    string       tag_q[$];

    always #2.5 clk = ~clk;

    pdn_standby_ctrl dut (
        .clk         (clk),
        .rst_pin_n   (rst_pin_n),
        .por_n       (por_n),
        .bus_wr      (bus_wr),
        .bus_rd      (bus_rd),
        .bus_addr    (bus_addr),
        .bus_wdata   (bus_wdata),
        .bus_rdata   (bus_rdata),
        .bus_rvalid  (bus_rvalid),
        .dstby_entry (dstby_entry),
        .periph_sel  (periph_sel),
        .clk_en      (clk_en),
        .periph_blk  (periph_blk),
        .periph_pass (periph_pass)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // Monitor: compare each read response with the oldest queued expectation.
    always @(negedge clk) begin
        if (bus_rvalid === 1'b1) begin
            n_cmp++;
            if (exp_q.size() == 0) begin
                n_bad++;
                $display("FAIL R4: actual unexpected response %h expected none", bus_rdata);
            end else begin
                automatic logic [15:0] e = exp_q.pop_front();
                automatic string       t = tag_q.pop_front();
                if (bus_rdata !== e) begin
                    n_bad++;
                    $display("FAIL %s: actual %h expected %h", t, bus_rdata, e);
                end
            end
        end
    end

    // All tasks start and end at a falling edge.
    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr(input logic [3:0] a, input logic [15:0] d);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd_pulse(input logic [3:0] a, input logic [15:0] e, input string tag);
        exp_q.push_back(e);
        tag_q.push_back(tag);
        bus_rd = 1'b1; bus_addr = a;
        @(negedge clk);
        bus_rd = 1'b0;
    endtask

    task automatic rd(input logic [3:0] a, input logic [15:0] e, input string tag);
        rd_pulse(a, e, tag);
        idle(2);
    endtask

    task automatic pulse_dstby();
        dstby_entry = 1'b1;
        @(negedge clk);
        dstby_entry = 1'b0;
    endtask

    task automatic pulse_por();
        por_n = 1'b0;
        @(negedge clk);
        por_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_cmp++;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        rst_pin_n = 1'b0; por_n = 1'b0;
        bus_wr = 1'b0; bus_rd = 1'b0; bus_addr = '0; bus_wdata = '0;
        dstby_entry = 1'b0; periph_sel = 16'hFFFF;
        idle(3);
        rst_pin_n = 1'b1; por_n = 1'b1;
        @(negedge clk);

        // R1: reset state
        chk("R1 clk_en", clk_en, 16'hFFFF);
        chk("R1 blk", periph_blk, 16'h0000);
        chk("R1 rvalid", bus_rvalid, 0);
        rd(4'h0, 16'h0000, "R1 standby");
        rd(4'h4, 16'h0000, "R1 cr2");

        // R3 then R2: enable moves only at commit
        wr(4'h0, 16'h00F5);
        chk("R3 pending keeps clk_en", clk_en, 16'hFFFF);
        @(negedge clk);
        chk("R2 clk_en after commit", clk_en, 16'hFF0A);
        chk("R6 blk", periph_blk, 16'h00F5);
        chk("R6 pass", periph_pass, 16'hFF0A);
        periph_sel = 16'h0F0F;
        #1;
        chk("R6 partial blk", periph_blk, 16'h0005);
        chk("R6 partial pass", periph_pass, 16'h0F0A);
        periph_sel = 16'hFFFF;
        @(negedge clk);

        // R4: stalled read right after write, then a normal read
        wr(4'h0, 16'h0F0F);
        rd_pulse(4'h0, 16'h0F0F, "R4 stalled read");
        chk("R4 stall no rvalid", bus_rvalid, 0);
        idle(3);
        rd_pulse(4'h0, 16'h0F0F, "R4 normal read");
        chk("R4 normal rvalid", bus_rvalid, 1);
        idle(2);

        // R2: clearing bits restores clocks
        wr(4'h0, 16'h0F00);
        idle(2);
        chk("R2 clear restores", clk_en, 16'hF0FF);

        // R10: unmapped offset
        wr(4'h8, 16'hFFFF);
        idle(2);
        rd(4'h8, 16'h0000, "R10 unmapped read");
        rd(4'h0, 16'h0F00, "R10 standby untouched");
        chk("R10 clk_en untouched", clk_en, 16'hF0FF);

        // R5: power-on reset clears only bits 0..3
        wr(4'h0, 16'hFFFF);
        wr(4'h4, 16'h0035);
        idle(2);
        pulse_por();
        chk("R5 clk_en after por", clk_en, 16'h000F);
        rd(4'h0, 16'hFFF0, "R5 standby after por");
        rd(4'h4, 16'h0035, "R5 cr2 after por");

        // R7: lock both top bits
        wr(4'h4, 16'h00C3);
        idle(2);
        pulse_dstby();
        wr(4'h4, 16'h0000);
        idle(2);
        rd(4'h4, 16'h00C0, "R7 locked bits stay");

        // R9: power-on reset keeps the lock
        pulse_por();
        wr(4'h4, 16'h0000);
        idle(2);
        rd(4'h4, 16'h00C0, "R9 lock survives por");

        // R9 and R1: reset pin clears everything including the lock
        rst_pin_n = 1'b0;
        idle(2);
        rst_pin_n = 1'b1;
        @(negedge clk);
        rd(4'h4, 16'h0000, "R9 cr2 after pin");
        rd(4'h0, 16'h0000, "R1 standby after pin");
        wr(4'h4, 16'h00C0);
        wr(4'h4, 16'h0000);
        idle(2);
        rd(4'h4, 16'h0000, "R9 unlocked clear");

        // R8: only bit 6 locked; bit 7 stays clearable, ones accepted
        wr(4'h4, 16'h0040);
        idle(2);
        pulse_dstby();
        wr(4'h4, 16'h0000);
        idle(2);
        rd(4'h4, 16'h0040, "R8 bit6 locked");
        wr(4'h4, 16'h0080);
        idle(2);
        rd(4'h4, 16'h00C0, "R8 write one accepted");
        wr(4'h4, 16'h0000);
        idle(2);
        rd(4'h4, 16'h0040, "R8 bit7 clearable");
        wr(4'h4, 16'h003F);
        idle(2);
        rd(4'h4, 16'h007F, "R8 low bits writable");

        idle(5);
        chk("R4 all responses seen", exp_q.size(), 0);
        finish_run();
    end

endmodule